// File: doc/BRIEF.md
# Bus Cycle Termination Controller

This block follows every bus cycle from its start strobe to its end and decides what ends it. A cycle opens when the active-low start strobe is sampled low. At that moment the block records who owns the bus (the local side or an external master), what kind of target is addressed (a chip-select region, default memory or DRAM) and which region's settings apply.

While the cycle is open, the block watches the completion sources that are valid for that kind of cycle:

- the slave's synchronous active-low acknowledge;
- an asynchronous active-low acknowledge, which the block synchronizes first;
- a completion pulse from the DRAM controller.

On external-master cycles the block can end the cycle itself. It drives the shared acknowledge pin low after the region's programmed wait states, drives the pin high for one clock, and then releases it.

The block has no streaming data interface. Every pin is a plain level or a single-clock pulse, so there is no back-pressure. Software-visible settings arrive as static configuration vectors: a 4-bit wait count and an auto-acknowledge enable for each region. The regions are chip-select 0..NUM_CS-1 and default memory at index NUM_CS.

Top module: `bus_term_ctrl`

## Requirements
- R1: After reset `ta_oe`, `cyc_busy`, `cyc_done` and `proto_err` are low and `ta_n_out` is high.
- R2: `ts_n` sampled low at a rising edge opens a cycle, and `cyc_busy` is high from the following clock until the edge at which the cycle ends. The target kind `tgt_kind` is encoded 0 = chip select (region `cs_idx`), 1 = default memory, 2 = DRAM, 3 = default memory.
- R3: On a local chip-select or default-memory cycle, `ta_n_in` low in any clock while the cycle is open raises `cyc_done` combinationally in that clock, and the cycle closes at the next edge.
- R4: On a local DRAM cycle, `ta_n_in` and `ata_n` have no effect. Only `dram_done` high ends the cycle, with `cyc_done` high in the same clock.
- R5: `ata_n` passes through a two-flop synchronizer. A low level sampled at edge e can end a cycle in the clock after edge e+1.
- R6: For an external-master chip-select or default-memory cycle whose region has auto-acknowledge enabled, the region's wait count W applies (0..15). `ta_n_out` is low with `ta_oe` high for exactly one clock, the (W+1)-th clock after the start clock, and `cyc_done` is high in that clock. `ta_n_in` and `ata_n` are ignored on such cycles.
- R7: After any clock in which the block drives the acknowledge low, it drives `ta_n_out` high with `ta_oe` high for one clock. `ta_oe` then falls unless a new driven acknowledge begins.
- R8: For an external-master cycle to a region with auto-acknowledge disabled, `ta_oe` stays low, and the cycle ends on `ta_n_in` low or on the synchronized `ata_n`.
- R9: For an external-master DRAM cycle, `dram_done` high in clock c makes the block drive `ta_n_out` low in clock c+1, with `cyc_done` high in that clock. Slave acknowledges are ignored.
- R10: `ts_n` low while a cycle is open and not ending in that clock raises `proto_err` for that clock, and a new cycle is tracked with the new attributes. `ts_n` low in the clock where the open cycle ends is a clean back-to-back start with no error.
- R11: Only the first qualifying completion ends a cycle. Acknowledges that arrive while no cycle is open raise no `cyc_done`.
- R12: The region's wait count and enable are taken from `cfg_wait[r*4 +: 4]` and `cfg_auto[r]` at the start edge. Here r = `cs_idx` for chip select and r = NUM_CS for default memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ts_n | input | 1 | Active-low start strobe, one clock per cycle |
| ext_master | input | 1 | High when an external master owns the bus, sampled with the start strobe |
| tgt_kind | input | 2 | Target kind, sampled with the start strobe (0 CS, 1 default, 2 DRAM, 3 default) |
| cs_idx | input | $clog2(NUM_CS) | Chip-select region index, sampled with the start strobe |
| cfg_wait | input | (NUM_CS+1)*WS_W | Per-region wait-state counts |
| cfg_auto | input | NUM_CS+1 | Per-region external-master auto-acknowledge enables |
| ta_n_in | input | 1 | Synchronous active-low acknowledge seen on the pin |
| ata_n | input | 1 | Asynchronous active-low acknowledge |
| dram_done | input | 1 | DRAM controller completion pulse |
| ta_n_out | output | 1 | Value driven on the acknowledge pin |
| ta_oe | output | 1 | Output enable of the acknowledge pin |
| cyc_busy | output | 1 | A cycle is open |
| cyc_done | output | 1 | The open cycle ends at the next edge |
| proto_err | output | 1 | Start strobe seen while a cycle was still open |

## Verification
The hardest situations to reach from the ports are coincidences. One is a start strobe in the very clock where a driven acknowledge ends the previous cycle. Another is a synchronized asynchronous acknowledge that is still in the pipeline after its cycle has closed. Directed sequences build both explicitly: a zero-wait external cycle followed at once by another strobe, and an asynchronous acknowledge held past cycle end and then a new cycle started. A long pseudo-random phase then mixes owners, target kinds, strobes and acknowledges, while a behavioural model predicts every output on every clock.

// File: rtl/bus_term_pkg.sv
package bus_term_pkg;

  typedef enum logic [1:0] {
    TGT_CS   = 2'd0,
    TGT_DFLT = 2'd1,
    TGT_DRAM = 2'd2,
    TGT_ALT  = 2'd3
  } tgt_e;

  // Encoding 3 is folded onto default memory.
  function automatic tgt_e norm_kind(tgt_e k);
    return (k == TGT_ALT) ? TGT_DFLT : k;
  endfunction

endpackage

// File: rtl/bt_ack_sync.sv
module bt_ack_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ata_n,
  output logic ack_q
);

  logic [STAGES-1:0] sh;

  always_ff @(posedge clk) begin
    if (!rst_n) sh <= '1;
    else        sh <= {sh[STAGES-2:0], ata_n};
  end

  assign ack_q = ~sh[STAGES-1];

endmodule

// File: rtl/bt_wait_timer.sv
module bt_wait_timer #(
  parameter int WS_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [WS_W-1:0] load_val,
  input  logic            clear,
  output logic            fire
);

  logic [WS_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (clear)        cnt <= '0;
    else if (cnt != '0)    cnt <= cnt - WS_W'(1);
  end

  // fire marks the edge after which the acknowledge clock begins
  assign fire = load ? (load_val == '0) : (cnt == WS_W'(1));

  assert_count_down_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0 && !load && !clear) |=> (cnt == $past(cnt) - WS_W'(1)));

endmodule

// File: rtl/bt_cycle_track.sv
module bt_cycle_track
  import bus_term_pkg::*;
#(
  parameter  int NUM_CS   = 4,
  parameter  int WS_W     = 4,
  localparam int CS_IDX_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
  localparam int NREG     = NUM_CS + 1,
  localparam int RIDX_W   = $clog2(NREG)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ts_n,
  input  logic                 ext_master,
  input  logic [1:0]           tgt_kind,
  input  logic [CS_IDX_W-1:0]  cs_idx,
  input  logic [NREG*WS_W-1:0] cfg_wait,
  input  logic [NREG-1:0]      cfg_auto,
  input  logic                 ta_n_in,
  input  logic                 ata_q,
  input  logic                 dram_done,
  input  logic                 drive_lo,
  output logic                 start,
  output logic                 open_q,
  output logic [WS_W-1:0]      wait_sel,
  output logic                 auto_now,
  output logic                 ext_dram_now,
  output logic                 done,
  output logic                 err
);

  logic [WS_W-1:0] wait_tab [NREG];
  logic            auto_tab [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    assign wait_tab[g] = cfg_wait[g*WS_W +: WS_W];
    assign auto_tab[g] = cfg_auto[g];
  end

  tgt_e             kind_in;
  logic [RIDX_W-1:0] rsel;
  logic             auto_sel;

  assign kind_in  = norm_kind(tgt_e'(tgt_kind));
  assign rsel     = (kind_in == TGT_CS) ? RIDX_W'(cs_idx) : RIDX_W'(NUM_CS);
  assign wait_sel = wait_tab[rsel];
  assign auto_sel = auto_tab[rsel];
  assign start    = ~ts_n;

  logic ext_q, auto_q;
  tgt_e kind_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      ext_q  <= 1'b0;
      auto_q <= 1'b0;
      kind_q <= TGT_CS;
    end else if (start) begin
      open_q <= 1'b1;
      ext_q  <= ext_master;
      auto_q <= auto_sel;
      kind_q <= kind_in;
    end else if (done) begin
      open_q <= 1'b0;
    end
  end

  logic auto_path_q;
  assign auto_path_q = ext_q && (kind_q != TGT_DRAM) && auto_q;

  always_comb begin
    if (!open_q)                done = 1'b0;
    else if (drive_lo)          done = 1'b1;
    else if (auto_path_q)       done = 1'b0;
    else if (kind_q == TGT_DRAM) done = !ext_q && dram_done;
    else                        done = !ta_n_in || ata_q;
  end

  assign err          = start && open_q && !done;
  assign auto_now     = start ? (ext_master && (kind_in != TGT_DRAM) && auto_sel)
                              : (open_q && auto_path_q);
  assign ext_dram_now = open_q && ext_q && (kind_q == TGT_DRAM);

  assert_dram_ignores_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (open_q && !ext_q && kind_q == TGT_DRAM && !dram_done) |-> !done);

  assert_close_after_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ts_n) |=> !open_q);

  assert_err_restarts_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> open_q);

endmodule

// File: rtl/bus_term_ctrl.sv
module bus_term_ctrl #(
  parameter  int NUM_CS      = 4,
  parameter  int WS_W        = 4,
  parameter  int SYNC_STAGES = 2,
  localparam int CS_IDX_W    = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
  localparam int NREG        = NUM_CS + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ts_n,
  input  logic                 ext_master,
  input  logic [1:0]           tgt_kind,
  input  logic [CS_IDX_W-1:0]  cs_idx,
  input  logic [NREG*WS_W-1:0] cfg_wait,
  input  logic [NREG-1:0]      cfg_auto,
  input  logic                 ta_n_in,
  input  logic                 ata_n,
  input  logic                 dram_done,
  output logic                 ta_n_out,
  output logic                 ta_oe,
  output logic                 cyc_busy,
  output logic                 cyc_done,
  output logic                 proto_err
);

  logic ata_q, start, open_q, auto_now, ext_dram_now, done, err, fire;
  logic drive_lo, drive_hi;
  logic [WS_W-1:0] wait_sel;

  bt_ack_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .ata_n (ata_n),
    .ack_q (ata_q)
  );

  bt_cycle_track #(.NUM_CS(NUM_CS), .WS_W(WS_W)) u_track (
    .clk          (clk),
    .rst_n        (rst_n),
    .ts_n         (ts_n),
    .ext_master   (ext_master),
    .tgt_kind     (tgt_kind),
    .cs_idx       (cs_idx),
    .cfg_wait     (cfg_wait),
    .cfg_auto     (cfg_auto),
    .ta_n_in      (ta_n_in),
    .ata_q        (ata_q),
    .dram_done    (dram_done),
    .drive_lo     (drive_lo),
    .start        (start),
    .open_q       (open_q),
    .wait_sel     (wait_sel),
    .auto_now     (auto_now),
    .ext_dram_now (ext_dram_now),
    .done         (done),
    .err          (err)
  );

  bt_wait_timer #(.WS_W(WS_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (start),
    .load_val (wait_sel),
    .clear    (done),
    .fire     (fire)
  );

  // Pin driver: a low clock, then one high clock, then release.
  logic lo_next;
  always_comb begin
    if (start)                lo_next = auto_now && fire;
    else if (open_q && !done) lo_next = (auto_now && fire) || (ext_dram_now && dram_done);
    else                      lo_next = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      drive_lo <= 1'b0;
      drive_hi <= 1'b0;
    end else begin
      drive_lo <= lo_next;
      drive_hi <= drive_lo;
    end
  end

  assign ta_oe     = drive_lo | drive_hi;
  assign ta_n_out  = ~drive_lo;
  assign cyc_busy  = open_q;
  assign cyc_done  = done;
  assign proto_err = err;

  assert_high_one_clock_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ta_oe && ta_n_out) |=> !(ta_oe && ta_n_out));

  assert_low_ends_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ta_n_out |-> (ta_oe && cyc_busy && cyc_done));

endmodule

// File: tb/tb_bus_term_ctrl.sv
`timescale 1ns/1ps
module tb_bus_term_ctrl;
  localparam int NCS = 4;
  localparam int WW  = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, ts_n, ext_master, ta_n_in, ata_n, dram_done;
  logic [1:0] tgt_kind, cs_idx;
  logic [(NCS+1)*WW-1:0] cfg_wait;
  logic [NCS:0] cfg_auto;
  logic ta_n_out, ta_oe, cyc_busy, cyc_done, proto_err;

  bus_term_ctrl dut (
    .clk(clk), .rst_n(rst_n), .ts_n(ts_n), .ext_master(ext_master),
    .tgt_kind(tgt_kind), .cs_idx(cs_idx), .cfg_wait(cfg_wait), .cfg_auto(cfg_auto),
    .ta_n_in(ta_n_in), .ata_n(ata_n), .dram_done(dram_done),
    .ta_n_out(ta_n_out), .ta_oe(ta_oe), .cyc_busy(cyc_busy),
    .cyc_done(cyc_done), .proto_err(proto_err)
  );

  int w_tab [5] = '{0, 3, 2, 1, 4};
  bit a_tab [5] = '{1, 0, 1, 0, 1};

  int vecs = 0, bad = 0;
  string req = "R1";

  // behavioural reference state
  bit m_open, m_ext, m_auto, m_lo, m_hi, s1, s2;
  int m_kind, m_left;

  task automatic model_reset();
    m_open = 0; m_ext = 0; m_auto = 0; m_lo = 0; m_hi = 0;
    s1 = 1; s2 = 1; m_kind = 0; m_left = 0;
  endtask

  task automatic cmp(string name, bit got, bit exp, inout bit miss);
    if (got !== exp) begin
      $display("FAIL %s %s: got %0b expected %0b at vector %0d", req, name, got, exp, vecs);
      miss = 1;
    end
  endtask

  task automatic step();
    bit e_done, e_err, miss, autop, n_lo, n_open, n_ext, n_auto;
    int n_kind, n_left, k, r;
    #1;
    autop = m_ext && m_kind != 2 && m_auto;
    if (!m_open)          e_done = 0;
    else if (m_lo)        e_done = 1;
    else if (autop)       e_done = 0;
    else if (m_kind == 2) e_done = !m_ext && dram_done;
    else                  e_done = !ta_n_in || !s2;
    e_err = !ts_n && m_open && !e_done;
    miss = 0;
    cmp("cyc_busy R2", cyc_busy, m_open, miss);
    cmp("cyc_done", cyc_done, e_done, miss);
    cmp("ta_oe R7", ta_oe, m_lo || m_hi, miss);
    cmp("ta_n_out R6", ta_n_out, !m_lo, miss);
    cmp("proto_err R10", proto_err, e_err, miss);
    vecs++;
    if (miss) bad++;
    n_open = m_open; n_ext = m_ext; n_auto = m_auto; n_kind = m_kind; n_left = m_left; n_lo = 0;
    if (!ts_n) begin
      k = (tgt_kind == 3) ? 1 : int'(tgt_kind);
      r = (k == 0) ? int'(cs_idx) : NCS;
      n_open = 1; n_ext = ext_master; n_kind = k; n_auto = a_tab[r]; n_left = w_tab[r];
      n_lo = ext_master && k != 2 && a_tab[r] && w_tab[r] == 0;
    end else if (m_open && e_done) begin
      n_open = 0; n_left = 0;
    end else if (m_open) begin
      n_lo = (autop && m_left == 1) || (m_ext && m_kind == 2 && dram_done);
      if (m_left > 0) n_left = m_left - 1;
    end
    @(posedge clk);
    m_hi = m_lo; m_lo = n_lo; m_open = n_open; m_ext = n_ext; m_auto = n_auto;
    m_kind = n_kind; m_left = n_left;
    s2 = s1; s1 = ata_n;
    @(negedge clk);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic begin_cyc(bit ext, int kind, int idx);
    ts_n = 0; ext_master = ext; tgt_kind = 2'(kind); cs_idx = 2'(idx);
    step();
    ts_n = 1;
  endtask

  task automatic pulse_ta();
    ta_n_in = 0; step(); ta_n_in = 1;
  endtask

  task automatic pulse_dram();
    dram_done = 1; step(); dram_done = 0;
  endtask

  initial begin
    #(200000 * 4);
    bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    cfg_wait = {4'd4, 4'd1, 4'd2, 4'd3, 4'd0};
    cfg_auto = 5'b10101;
    rst_n = 0; ts_n = 1; ext_master = 0; tgt_kind = 0; cs_idx = 0;
    ta_n_in = 1; ata_n = 1; dram_done = 0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    req = "R1"; idle(2);                                   // reset state

    req = "R2 R3"; begin_cyc(0, 0, 1); idle(2); pulse_ta(); idle(1);

    req = "R4"; begin_cyc(0, 2, 0); pulse_ta();
    ata_n = 0; idle(3); ata_n = 1; idle(2); pulse_dram(); idle(2);

    req = "R5"; begin_cyc(0, 1, 0); ata_n = 0; idle(4); ata_n = 1; idle(3);

    req = "R6 R7"; begin_cyc(1, 0, 0); idle(4);            // zero waits
    req = "R6";    begin_cyc(1, 0, 2); pulse_ta(); idle(5); // slave ack ignored
    req = "R12";   begin_cyc(1, 1, 0); idle(7);
    req = "R12";   begin_cyc(1, 3, 0); idle(7);
    req = "R12";   begin_cyc(1, 0, 3); pulse_ta(); idle(2);  // auto off region

    req = "R8"; begin_cyc(1, 0, 1); idle(3); pulse_ta(); idle(2);
    req = "R8"; begin_cyc(1, 0, 3); ata_n = 0; idle(4); ata_n = 1; idle(2);

    req = "R9"; begin_cyc(1, 2, 0); pulse_ta(); idle(1); pulse_dram(); idle(3);

    req = "R10"; begin_cyc(0, 0, 0); idle(1); begin_cyc(0, 1, 0); idle(1); pulse_ta(); idle(1);
    req = "R10"; begin_cyc(1, 0, 0); begin_cyc(1, 0, 2); idle(5);  // back-to-back, no error

    req = "R11"; begin_cyc(0, 0, 2); ata_n = 0; idle(2); ta_n_in = 0; step();
    ta_n_in = 1; idle(2); ata_n = 1; pulse_ta(); idle(3);

    req = "R2 mix";
    for (int i = 0; i < 600; i++) begin
      ts_n       = ($urandom_range(0, 5) != 0);
      ext_master = 1'($urandom_range(0, 1));
      tgt_kind   = 2'($urandom_range(0, 3));
      cs_idx     = 2'($urandom_range(0, 3));
      ta_n_in    = ($urandom_range(0, 4) != 0);
      dram_done  = ($urandom_range(0, 5) == 0);
      if ($urandom_range(0, 3) == 0) ata_n = ~ata_n;
      step();
    end
    ts_n = 1; ta_n_in = 1; dram_done = 0; ata_n = 1; idle(4);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

endmodule